// File: doc/BRIEF.md
# SRAM Pattern Self-Test and Signature Engine

This engine drives a byte-wide synchronous SRAM through one of four operations chosen at the command port. Fill writes a counting byte pattern over a region. Verify regenerates that pattern and compares it with each location. Sign reads the region and accumulates a 16-bit sum and an 8-bit XOR of its bytes. Probe only checks that a memory is attached. Every command that covers at least one byte first probes the region's base location. The engine saves that byte, writes 55h and reads it back, writes AAh and reads it back, then restores the saved byte. This tells a missing or floating memory apart from a data fault.

The controller is one state machine. From ST_IDLE, an accepted start with a non-zero length goes to ST_SAVE_RD and then to ST_SAVE_CAP. The probe runs through ST_PROBE_WLO, ST_PROBE_RLO and ST_PROBE_CLO, then ST_PROBE_WHI, ST_PROBE_RHI and ST_PROBE_CHI. A failed read-back in either check state returns to ST_IDLE with the no-memory flag set. Otherwise the machine goes to ST_RESTORE. From ST_RESTORE it branches on the operation. Fill goes to ST_FILL. Verify and Sign go to ST_RD_ISSUE, which alternates with ST_RD_CHECK. Probe goes back to ST_IDLE. ST_FILL and ST_RD_CHECK return to ST_IDLE after the last byte. ST_RD_CHECK also returns to ST_IDLE on the first mismatch.

Software issues one command, waits for done, then reads the status: error flag, no-memory flag, failure address and bytes, sum and XOR.

Top module: `sram_selftest`

## Requirements
- R1: A start pulse while busy is low latches op, pattern, base and length, and busy is high in the next cycle when the length is non-zero. A start while busy is high is ignored.
- R2: Every non-empty command first reads the base byte, writes and reads back 55h, then writes and reads back AAh, then writes the saved byte back, so the base content is unchanged. If a read-back differs, the command ends with no-memory set and error clear, and no further access is made: 3 accesses when 55h fails, 5 when AAh fails.
- R3: With cmd_desc = 0, the byte for region index i is i mod 256 (00, 01, … FF, 00, …).
- R4: With cmd_desc = 1, the byte for region index i is FFh minus (i mod 256) (FF, FE, … 00, FF, …).
- R5: Op encoding: 0 = fill, 1 = verify, 2 = sign, 3 = probe only.
- R6: A verify over a region that fully matches ends with done set and error clear.
- R7: A verify stops at the first mismatch. It reports the failing address, the expected byte and the byte read, and it reads no later location: the probe's 6 accesses plus i+1 reads for a failure at index i. The failure fields hold until the next accepted start.
- R8: Sign returns the sum of all region bytes modulo 2^16 and the XOR of all region bytes.
- R9: The address for index i is (base + i) mod 2^ADDR_W, and a length of 2^ADDR_W covers the whole memory.
- R10: A start with length zero sets done in the next cycle with no memory access, with sum and XOR both zero.
- R11: Done, error, no-memory and the results hold until the next accepted start. Busy and done are never high together.
- R12: After reset, busy, done, error, no-memory and the memory enable are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Start pulse |
| cmd_op | input | 2 | Operation select (R5) |
| cmd_desc | input | 1 | 0 ascending, 1 descending pattern |
| cmd_base | input | ADDR_W | Region base address |
| cmd_len | input | ADDR_W+1 | Region length in bytes |
| mem_en | output | 1 | SRAM access enable |
| mem_we | output | 1 | SRAM write enable |
| mem_addr | output | ADDR_W | SRAM address |
| mem_wdata | output | 8 | SRAM write data |
| mem_rdata | input | 8 | SRAM read data, valid the cycle after a read |
| st_busy | output | 1 | Command in progress |
| st_done | output | 1 | Last command finished |
| st_err | output | 1 | Verify mismatch found |
| st_nomem | output | 1 | Probe found no working memory |
| st_fail_addr | output | ADDR_W | Address of first mismatch |
| st_fail_exp | output | 8 | Expected byte at mismatch |
| st_fail_act | output | 8 | Byte read at mismatch |
| st_sum | output | 16 | Modulo-2^16 byte sum |
| st_xor | output | 8 | XOR of all bytes |

## Verification
The bench wraps the pattern past 256 bytes and also wraps the address past the top of memory. A design that truncates the index or the address would write the wrong bytes or write outside the region. It plants a single bad byte and counts the accesses made at the port. An engine that scans on after the mismatch, or reports the wrong address or byte, fails there. It models a missing memory and one that returns a constant 55h. A probe that skips the AAh step would report a data error instead of no-memory. Further tests cover a full-memory sum that overflows 16 bits, a zero-length command and a start pulse sent mid-command.

// File: rtl/sram_selftest_pkg.sv
package sram_selftest_pkg;

    typedef enum logic [1:0] {
        OP_FILL   = 2'd0,
        OP_VERIFY = 2'd1,
        OP_SIGN   = 2'd2,
        OP_PROBE  = 2'd3
    } op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SAVE_RD,
        ST_SAVE_CAP,
        ST_PROBE_WLO,
        ST_PROBE_RLO,
        ST_PROBE_CLO,
        ST_PROBE_WHI,
        ST_PROBE_RHI,
        ST_PROBE_CHI,
        ST_RESTORE,
        ST_FILL,
        ST_RD_ISSUE,
        ST_RD_CHECK
    } state_e;

endpackage

// File: rtl/stest_patgen.sv
module stest_patgen #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] idx,
    input  logic              desc,
    output logic [DATA_W-1:0] pat
);
    // Ascending ramp is the index itself; descending is its complement,
    // which equals all-ones minus the index and wraps the same way.
    always_comb begin
        pat = desc ? ~idx : idx;
    end
endmodule

// File: rtl/stest_sig.sv
module stest_sig #(
    parameter int DATA_W = 8,
    parameter int SUM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              add,
    input  logic [DATA_W-1:0] din,
    output logic [SUM_W-1:0]  sum,
    output logic [DATA_W-1:0] xsig
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum  <= '0;
            xsig <= '0;
        end else if (clr) begin
            sum  <= '0;
            xsig <= '0;
        end else if (add) begin
            sum  <= sum + SUM_W'(din);
            xsig <= xsig ^ din;
        end
    end
endmodule

// File: rtl/stest_ctrl.sv
module stest_ctrl
    import sram_selftest_pkg::*;
#(
    parameter  int ADDR_W = 10,
    parameter  int DATA_W = 8,
    localparam int LEN_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic              desc,
    input  logic [ADDR_W-1:0] base,
    input  logic [LEN_W-1:0]  len,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] pat_idx,
    output logic              pat_desc,
    input  logic [DATA_W-1:0] pat_byte,
    output logic              sig_clr,
    output logic              sig_add,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              nomem,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [DATA_W-1:0] fail_exp,
    output logic [DATA_W-1:0] fail_act
);
    localparam logic [DATA_W-1:0] PRB_LO = {(DATA_W/2){2'b01}};
    localparam logic [DATA_W-1:0] PRB_HI = ~PRB_LO;

    state_e            state_q, state_d;
    op_e               op_q;
    logic              desc_q;
    logic [ADDR_W-1:0] base_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  idx_q;
    logic [DATA_W-1:0] saved_q;
    logic              done_q, err_q, nomem_q;
    logic [ADDR_W-1:0] faddr_q;
    logic [DATA_W-1:0] fexp_q, fact_q;

    logic              accept;
    logic              last;
    logic              lo_ok, hi_ok, miss;
    logic [ADDR_W-1:0] cur_addr;

    assign accept   = (state_q == ST_IDLE) && start;
    assign last     = (idx_q == len_q - LEN_W'(1));
    assign lo_ok    = (mem_rdata == PRB_LO);
    assign hi_ok    = (mem_rdata == PRB_HI);
    assign miss     = (op_q == OP_VERIFY) && (mem_rdata != pat_byte);
    assign cur_addr = base_q + idx_q[ADDR_W-1:0];
    assign pat_idx  = DATA_W'(idx_q);
    assign pat_desc = desc_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start && (len != '0)) state_d = ST_SAVE_RD;
            ST_SAVE_RD:   state_d = ST_SAVE_CAP;
            ST_SAVE_CAP:  state_d = ST_PROBE_WLO;
            ST_PROBE_WLO: state_d = ST_PROBE_RLO;
            ST_PROBE_RLO: state_d = ST_PROBE_CLO;
            ST_PROBE_CLO: state_d = lo_ok ? ST_PROBE_WHI : ST_IDLE;
            ST_PROBE_WHI: state_d = ST_PROBE_RHI;
            ST_PROBE_RHI: state_d = ST_PROBE_CHI;
            ST_PROBE_CHI: state_d = hi_ok ? ST_RESTORE : ST_IDLE;
            ST_RESTORE: begin
                unique case (op_q)
                    OP_FILL:   state_d = ST_FILL;
                    OP_VERIFY: state_d = ST_RD_ISSUE;
                    OP_SIGN:   state_d = ST_RD_ISSUE;
                    OP_PROBE:  state_d = ST_IDLE;
                    default:   state_d = ST_IDLE;
                endcase
            end
            ST_FILL:      if (last) state_d = ST_IDLE;
            ST_RD_ISSUE:  state_d = ST_RD_CHECK;
            ST_RD_CHECK:  state_d = (miss || last) ? ST_IDLE : ST_RD_ISSUE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = base_q;
        mem_wdata = '0;
        sig_add   = 1'b0;
        sig_clr   = accept;
        busy      = (state_q != ST_IDLE);
        unique case (state_q)
            ST_SAVE_RD:   mem_en = 1'b1;
            ST_PROBE_WLO: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = PRB_LO;
            end
            ST_PROBE_RLO: mem_en = 1'b1;
            ST_PROBE_WHI: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = PRB_HI;
            end
            ST_PROBE_RHI: mem_en = 1'b1;
            ST_RESTORE: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = saved_q;
            end
            ST_FILL: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_addr;
                mem_wdata = pat_byte;
            end
            ST_RD_ISSUE: begin
                mem_en   = 1'b1;
                mem_addr = cur_addr;
            end
            ST_RD_CHECK:  sig_add = (op_q == OP_SIGN);
            default: ;
        endcase
    end

    // Command and status registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_FILL;
            desc_q  <= 1'b0;
            base_q  <= '0;
            len_q   <= '0;
            idx_q   <= '0;
            saved_q <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            nomem_q <= 1'b0;
            faddr_q <= '0;
            fexp_q  <= '0;
            fact_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        op_q    <= op_e'(op);
                        desc_q  <= desc;
                        base_q  <= base;
                        len_q   <= len;
                        idx_q   <= '0;
                        done_q  <= (len == '0);
                        err_q   <= 1'b0;
                        nomem_q <= 1'b0;
                        faddr_q <= '0;
                        fexp_q  <= '0;
                        fact_q  <= '0;
                    end
                end
                ST_SAVE_CAP:  saved_q <= mem_rdata;
                ST_PROBE_CLO: if (!lo_ok) begin
                    nomem_q <= 1'b1;
                    done_q  <= 1'b1;
                end
                ST_PROBE_CHI: if (!hi_ok) begin
                    nomem_q <= 1'b1;
                    done_q  <= 1'b1;
                end
                ST_RESTORE:   if (op_q == OP_PROBE) done_q <= 1'b1;
                ST_FILL: begin
                    if (last) done_q <= 1'b1;
                    else      idx_q  <= idx_q + LEN_W'(1);
                end
                ST_RD_CHECK: begin
                    if (miss) begin
                        err_q   <= 1'b1;
                        faddr_q <= cur_addr;
                        fexp_q  <= pat_byte;
                        fact_q  <= mem_rdata;
                        done_q  <= 1'b1;
                    end else if (last) begin
                        done_q  <= 1'b1;
                    end else begin
                        idx_q   <= idx_q + LEN_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    assign done      = done_q;
    assign err       = err_q;
    assign nomem     = nomem_q;
    assign fail_addr = faddr_q;
    assign fail_exp  = fexp_q;
    assign fail_act  = fact_q;
endmodule

// File: rtl/sram_selftest.sv
module sram_selftest #(
    parameter  int ADDR_W = 10,
    parameter  int SUM_W  = 16,
    localparam int DATA_W = 8,
    localparam int LEN_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [1:0]        cmd_op,
    input  logic              cmd_desc,
    input  logic [ADDR_W-1:0] cmd_base,
    input  logic [LEN_W-1:0]  cmd_len,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              st_busy,
    output logic              st_done,
    output logic              st_err,
    output logic              st_nomem,
    output logic [ADDR_W-1:0] st_fail_addr,
    output logic [DATA_W-1:0] st_fail_exp,
    output logic [DATA_W-1:0] st_fail_act,
    output logic [SUM_W-1:0]  st_sum,
    output logic [DATA_W-1:0] st_xor
);
    logic [DATA_W-1:0] pat_idx;
    logic [DATA_W-1:0] pat_byte;
    logic              pat_desc;
    logic              sig_clr, sig_add;

    stest_patgen #(.DATA_W(DATA_W)) u_pat (
        .idx  (pat_idx),
        .desc (pat_desc),
        .pat  (pat_byte)
    );

    stest_sig #(.DATA_W(DATA_W), .SUM_W(SUM_W)) u_sig (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (sig_clr),
        .add  (sig_add),
        .din  (mem_rdata),
        .sum  (st_sum),
        .xsig (st_xor)
    );

    stest_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cmd_start),
        .op       (cmd_op),
        .desc     (cmd_desc),
        .base     (cmd_base),
        .len      (cmd_len),
        .mem_en   (mem_en),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata),
        .pat_idx  (pat_idx),
        .pat_desc (pat_desc),
        .pat_byte (pat_byte),
        .sig_clr  (sig_clr),
        .sig_add  (sig_add),
        .busy     (st_busy),
        .done     (st_done),
        .err      (st_err),
        .nomem    (st_nomem),
        .fail_addr(st_fail_addr),
        .fail_exp (st_fail_exp),
        .fail_act (st_fail_act)
    );
endmodule

// File: rtl/sram_selftest_checker.sv
module sram_selftest_checker #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_start,
    input logic [ADDR_W:0]   cmd_len,
    input logic              mem_en,
    input logic              st_busy,
    input logic              st_done,
    input logic              st_err,
    input logic              st_nomem,
    input logic [ADDR_W-1:0] st_fail_addr,
    input logic [7:0]        st_fail_exp,
    input logic [7:0]        st_fail_act
);
    assert_start_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && !st_busy && (cmd_len != '0)) |=> st_busy);

    assert_nomem_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_nomem) |-> (st_done && !st_busy && !st_err));

    assert_flag_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_err && st_nomem));

    assert_fail_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_err && !cmd_start) |=> (st_err && $stable(st_fail_addr)
                                    && $stable(st_fail_exp) && $stable(st_fail_act)));

    assert_done_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_done && !cmd_start) |=> st_done);

    assert_busy_done_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_busy && st_done));

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !st_busy |-> !mem_en);
endmodule

bind sram_selftest sram_selftest_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_start   (cmd_start),
    .cmd_len     (cmd_len),
    .mem_en      (mem_en),
    .st_busy     (st_busy),
    .st_done     (st_done),
    .st_err      (st_err),
    .st_nomem    (st_nomem),
    .st_fail_addr(st_fail_addr),
    .st_fail_exp (st_fail_exp),
    .st_fail_act (st_fail_act)
);

// File: tb/sim_sram_selftest.sv
module sim_sram_selftest;
    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;
    localparam int NVEC  = 10;

    // {op[1:0], desc, base[9:0], len[10:0]}
    localparam logic [23:0] VEC [NVEC] = '{
        {2'd0, 1'b0, 10'd0,    11'd300},
        {2'd1, 1'b0, 10'd0,    11'd300},
        {2'd2, 1'b0, 10'd0,    11'd300},
        {2'd0, 1'b1, 10'd400,  11'd260},
        {2'd1, 1'b1, 10'd400,  11'd260},
        {2'd1, 1'b0, 10'd400,  11'd10},
        {2'd0, 1'b0, 10'd1000, 11'd50},
        {2'd1, 1'b0, 10'd1000, 11'd50},
        {2'd2, 1'b1, 10'd1000, 11'd50},
        {2'd3, 1'b0, 10'd700,  11'd1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_start = 1'b0;
    logic [1:0]    cmd_op = 2'd0;
    logic          cmd_desc = 1'b0;
    logic [AW-1:0] cmd_base = '0;
    logic [AW:0]   cmd_len = '0;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata = 8'h00;
    logic          st_busy, st_done, st_err, st_nomem;
    logic [AW-1:0] st_fail_addr;
    logic [7:0]    st_fail_exp, st_fail_act, st_xor;
    logic [15:0]   st_sum;

    logic [7:0] ram [DEPTH];
    int         mem_mode = 0;  // 0 normal, 1 absent (reads FFh), 2 stuck at 55h
    int         acc_cnt = 0;
    int         total = 0;
    int         bad = 0;

    always #10 clk = ~clk;

    sram_selftest #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
        .cmd_desc(cmd_desc), .cmd_base(cmd_base), .cmd_len(cmd_len),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .st_busy(st_busy), .st_done(st_done), .st_err(st_err),
        .st_nomem(st_nomem), .st_fail_addr(st_fail_addr),
        .st_fail_exp(st_fail_exp), .st_fail_act(st_fail_act),
        .st_sum(st_sum), .st_xor(st_xor)
    );

    always @(posedge clk) begin
        if (mem_en) begin
            acc_cnt <= acc_cnt + 1;
            if (mem_we) begin
                if (mem_mode == 0) ram[mem_addr] <= mem_wdata;
            end else begin
                mem_rdata <= (mem_mode == 0) ? ram[mem_addr] :
                             (mem_mode == 1) ? 8'hFF : 8'h55;
            end
        end
    end

    function automatic logic [7:0] pat(input logic d, input int i);
        logic [7:0] b;
        b = 8'(i);
        return d ? 8'hFF - b : b;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [1:0] op, input logic d,
                           input logic [AW-1:0] b, input logic [AW:0] l);
        bit ok;
        @(negedge clk);
        cmd_op = op; cmd_desc = d; cmd_base = b; cmd_len = l; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        ok = 1'b0;
        for (int n = 0; n < 5000; n++) begin
            if (st_done) begin
                ok = 1'b1;
                break;
            end
            @(negedge clk);
        end
        if (!ok) chk(1'b0, "R11 done timeout", 0, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) ram[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(!st_busy && !st_done && !st_err && !st_nomem && !mem_en,
            "R12 reset outputs", {st_busy, st_done, st_err, st_nomem, mem_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table walk
        for (int v = 0; v < NVEC; v++) begin
            logic [1:0]    op;
            logic          d;
            logic [AW-1:0] b;
            int            l, kmiss, esum, exor, nbad;
            logic [7:0]    saved, ebyte;
            op = VEC[v][23:22]; d = VEC[v][21]; b = VEC[v][20:11]; l = int'(VEC[v][10:0]);
            saved = ram[b];
            kmiss = -1; esum = 0; exor = 0; ebyte = 8'h00;
            for (int i = 0; i < l; i++) begin
                logic [7:0] m;
                m = ram[(int'(b) + i) % DEPTH];
                esum = esum + int'(m);
                exor = exor ^ int'(m);
                if (kmiss < 0 && m != pat(d, i)) begin
                    kmiss = i;
                    ebyte = m;
                end
            end
            run_cmd(op, d, b, 11'(l));
            chk(st_done && !st_busy && !st_nomem, "R11 done after vector", {st_done, st_busy, st_nomem}, 3'b100);
            case (op)
                2'd0: begin
                    nbad = 0;
                    for (int i = 0; i < l; i++)
                        if (ram[(int'(b) + i) % DEPTH] != pat(d, i)) nbad++;
                    chk(nbad == 0, d ? "R4 R9 R5 descending fill" : "R3 R9 R5 ascending fill", nbad, 0);
                end
                2'd1: begin
                    if (kmiss < 0) begin
                        chk(!st_err, "R6 clean verify", st_err, 0);
                    end else begin
                        chk(st_err, "R7 error flag", st_err, 1);
                        chk(st_fail_addr == AW'((int'(b) + kmiss) % DEPTH), "R7 fail address",
                            st_fail_addr, (int'(b) + kmiss) % DEPTH);
                        chk(st_fail_exp == pat(d, kmiss) && st_fail_act == ebyte, "R7 fail bytes",
                            {st_fail_exp, st_fail_act}, {pat(d, kmiss), ebyte});
                    end
                end
                2'd2: begin
                    chk(st_sum == 16'(esum), "R8 sum", st_sum, esum & 16'hFFFF);
                    chk(st_xor == 8'(exor), "R8 xor", st_xor, exor & 8'hFF);
                end
                default: chk(!st_err, "R5 probe-only no error", st_err, 0);
            endcase
            if (op != 2'd0)
                chk(ram[b] == saved, "R2 base restored", ram[b], saved);
        end

        // R7: mismatch in the middle, stop at first failure
        begin
            int a0;
            run_cmd(2'd0, 1'b0, 10'd100, 11'd40);
            @(negedge clk);
            ram[117] = 8'h3C;
            ram[125] = 8'h00;
            a0 = acc_cnt;
            run_cmd(2'd1, 1'b0, 10'd100, 11'd40);
            chk(st_err && st_fail_addr == 10'd117, "R7 directed fail address", st_fail_addr, 117);
            chk(st_fail_exp == 8'h11 && st_fail_act == 8'h3C, "R7 directed fail bytes",
                {st_fail_exp, st_fail_act}, 16'h113C);
            chk(acc_cnt - a0 == 24, "R7 no reads after mismatch", acc_cnt - a0, 24);
            repeat (5) @(negedge clk);
            chk(st_err && st_done && st_fail_addr == 10'd117, "R11 status held", {st_err, st_done}, 2'b11);
        end

        // R1: start during a command is ignored
        begin
            bit ok;
            int nbad;
            for (int i = 0; i < 100; i++) ram[i] = 8'hEE;
            @(negedge clk);
            cmd_op = 2'd0; cmd_desc = 1'b0; cmd_base = 10'd0; cmd_len = 11'd100; cmd_start = 1'b1;
            @(negedge clk);
            cmd_start = 1'b0;
            chk(st_busy, "R1 busy after start", st_busy, 1);
            repeat (10) @(negedge clk);
            cmd_op = 2'd3; cmd_len = 11'd0; cmd_start = 1'b1;
            @(negedge clk);
            cmd_start = 1'b0;
            chk(st_busy && !st_done, "R1 mid-command start ignored", {st_busy, st_done}, 2'b10);
            ok = 1'b0;
            for (int n = 0; n < 2000; n++) begin
                if (st_done) begin ok = 1'b1; break; end
                @(negedge clk);
            end
            nbad = 0;
            for (int i = 0; i < 100; i++) if (ram[i] != 8'(i)) nbad++;
            chk(ok && nbad == 0, "R1 original fill completed", nbad, 0);
        end

        // R10: zero length
        begin
            int a0;
            a0 = acc_cnt;
            run_cmd(2'd2, 1'b0, 10'd50, 11'd0);
            chk(st_done && !st_busy && acc_cnt == a0, "R10 zero length no access", acc_cnt - a0, 0);
            chk(st_sum == 16'd0 && st_xor == 8'd0, "R10 zero results", {st_sum, st_xor}, 0);
        end

        // R2: memory absent
        begin
            int a0;
            mem_mode = 1;
            a0 = acc_cnt;
            run_cmd(2'd1, 1'b0, 10'd0, 11'd10);
            chk(st_nomem && !st_err, "R2 absent memory flag", {st_nomem, st_err}, 2'b10);
            chk(acc_cnt - a0 == 3, "R2 absent access count", acc_cnt - a0, 3);
            mem_mode = 2;
            a0 = acc_cnt;
            run_cmd(2'd0, 1'b0, 10'd0, 11'd10);
            chk(st_nomem && !st_err, "R2 stuck 55h flag", {st_nomem, st_err}, 2'b10);
            chk(acc_cnt - a0 == 5, "R2 stuck 55h access count", acc_cnt - a0, 5);
            mem_mode = 0;
        end

        // R8 R9: full memory sum overflow with base wrap
        begin
            for (int i = 0; i < DEPTH; i++) ram[i] = 8'hFF;
            run_cmd(2'd2, 1'b0, 10'd5, 11'(DEPTH));
            chk(st_sum == 16'hFC00, "R8 R9 full-region sum wraps", st_sum, 16'hFC00);
            chk(st_xor == 8'h00 && !st_nomem, "R8 full-region xor", st_xor, 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule